// File: doc/BRIEF.md
# Serial DAC Write Sequencer with Load Strobe

This block takes a 12-bit sample together with a gain choice and a power-down choice, and writes them to a single-channel serial DAC over a write-only SPI link. A write has four parts: a start request is accepted, a 16-bit frame is shifted out, a separate active-low load strobe is pulsed so that the converter moves the new word to its output, and a fixed idle gap passes before the next request can be taken. The serial clock is the system clock (40 MHz in the target) divided by four.

The sample and the two control bits are copied into a holding register when a request is accepted. The driving logic may change its inputs as soon as `busy` rises. A request is taken only while `en` is high and the block is idle. Requests seen at any other time are dropped and are not queued.

The controller has seven states. `ST_IDLE` waits for a request. `ST_CHECK` builds the frame from the held inputs. `ST_ARM` pulls chip select low and presents the first bit. `ST_SHIFT` runs the serial clock for 16 bits. `ST_STROBE` holds the load strobe low. `ST_RELEASE` lets the strobe go high again. `ST_GAP` waits out the idle gap.

The transitions are as follows:
- IDLE→CHECK on start with enable.
- CHECK→ARM and ARM→SHIFT unconditionally.
- SHIFT→STROBE after the 16th bit.
- STROBE→RELEASE when the strobe timer expires.
- RELEASE→GAP unconditionally.
- GAP→IDLE when the gap timer expires.

Top module: `dac_write_seq`

## Requirements
- R1: When `start_req` and `en` are both high while `busy` is low, the request is accepted and `busy` is high in the next cycle.
- R2: A request made while `en` is low, or while `busy` is high, is ignored: no frame starts, and no further frame follows the current one.
- R3: The frame is 16 bits long and is sent MSB first. Bit 15 is 0 and bit 14 is 0. Bit 13 is the inverse of `gain_hi`. Bit 12 is the inverse of `pwr_down`. Bits 11..0 are the sample.
- R4: `sclk` has a period of 4 system clocks and idles low whenever `cs_n` is high. There are exactly 16 rising edges per frame. `sdo` changes only while `sclk` is low.
- R5: `cs_n` falls at least 2 system clocks before the first rising edge of `sclk`, and it rises only after the 16th rising edge.
- R6: After the frame, `load_n` is low for exactly 4 system clocks, and it is low only while `cs_n` is high.
- R7: After `load_n` returns high, `busy` stays high for exactly 9 more cycles: 1 release cycle plus an 8-cycle gap. The block then accepts requests again.
- R8: Changes to `sample`, `gain_hi` or `pwr_down` after acceptance do not alter the frame being sent.
- R9: While reset is held, and after it is released, the outputs are at rest: `cs_n`=1, `sclk`=0, `sdo`=0, `load_n`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to write one sample |
| sample | input | 12 | Sample word to convert |
| en | input | 1 | Allows requests to be accepted |
| gain_hi | input | 1 | 0 selects 1x gain, 1 selects 2x gain |
| pwr_down | input | 1 | 1 requests converter shutdown |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the converter |
| load_n | output | 1 | Active-low load strobe |
| busy | output | 1 | High from acceptance to the end of the gap |

## Verification
`busy` is due one cycle after the accepting edge. `cs_n` falls two cycles after acceptance. The first `sclk` rise follows three cycles after that, and each later rise follows 4 cycles after the one before. `load_n` falls on the cycle after the 16th bit, stays low for 4 cycles, and `busy` drops 9 cycles after the strobe ends. The bench samples every output on the falling system clock edge, which is half a period after the registers change. It deserializes `sdo` on each observed `sclk` rise and measures every interval in counted cycles, checking each one against these exact figures.

// File: rtl/dws_pkg.sv
package dws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ARM,
        ST_SHIFT,
        ST_STROBE,
        ST_RELEASE,
        ST_GAP
    } dws_state_t;
endpackage

// File: rtl/dws_sclk_gen.sv
module dws_sclk_gen #(
    parameter int DIV   = 4,
    parameter int NBITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_pt,
    output logic last_bit
);
    localparam int PW = $clog2(DIV);
    localparam int BW = $clog2(NBITS);
    localparam logic [PW-1:0] HALF = PW'(DIV / 2);
    localparam logic [PW-1:0] LASTPH = PW'(DIV - 1);
    localparam logic [BW-1:0] LASTB = BW'(NBITS - 1);

    logic [PW-1:0] phase;
    logic [BW-1:0] bitcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= '0;
            bitcnt <= '0;
        end else if (!run) begin
            phase  <= '0;
            bitcnt <= '0;
        end else begin
            phase <= phase + 1'b1;
            if (phase == LASTPH) bitcnt <= bitcnt + 1'b1;
        end
    end

    assign sclk     = run && (phase >= HALF);
    assign fall_pt  = run && (phase == LASTPH);
    assign last_bit = fall_pt && (bitcnt == LASTB);
endmodule

// File: rtl/dws_shifter.sv
module dws_shifter #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [FW-1:0] frame_in,
    output logic          msb
);
    logic [FW-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= frame_in;
        else if (shift) sr <= {sr[FW-2:0], 1'b0};
    end

    assign msb = sr[FW-1];
endmodule

// File: rtl/dws_timer.sv
module dws_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq #(
    parameter int DATA_W   = 12,
    parameter int DIV      = 4,
    parameter int LOAD_CYC = 4,
    parameter int GAP_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [DATA_W-1:0] sample,
    input  logic              en,
    input  logic              gain_hi,
    input  logic              pwr_down,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo,
    output logic              load_n,
    output logic              busy
);
    import dws_pkg::*;

    localparam int FRAME_W = DATA_W + 4;
    localparam int TMAX    = (LOAD_CYC > GAP_CYC) ? LOAD_CYC : GAP_CYC;
    localparam int TW      = $clog2(TMAX + 1);

    dws_state_t state, nxt;

    logic [DATA_W-1:0] hold_data;
    logic              hold_gain, hold_pd;
    logic              accept;
    logic              fall_pt, last_bit, tmr_zero, msb;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic [FRAME_W-1:0] frame;

    assign accept = (state == ST_IDLE) && start_req && en;
    assign frame  = {1'b0, 1'b0, ~hold_gain, ~hold_pd, hold_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_gain <= 1'b0;
            hold_pd   <= 1'b0;
        end else if (accept) begin
            hold_data <= sample;
            hold_gain <= gain_hi;
            hold_pd   <= pwr_down;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (accept) nxt = ST_CHECK;
            ST_CHECK:   nxt = ST_ARM;
            ST_ARM:     nxt = ST_SHIFT;
            ST_SHIFT:   if (last_bit) nxt = ST_STROBE;
            ST_STROBE:  if (tmr_zero) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_GAP;
            ST_GAP:     if (tmr_zero) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        cs_n   = 1'b1;
        load_n = 1'b1;
        busy   = 1'b1;
        sdo    = 1'b0;
        unique case (state)
            ST_IDLE:           busy = 1'b0;
            ST_ARM, ST_SHIFT: begin
                cs_n = 1'b0;
                sdo  = msb;
            end
            ST_STROBE:         load_n = 1'b0;
            default:           ;
        endcase
    end

    assign tmr_load = ((state == ST_SHIFT) && last_bit) || (state == ST_RELEASE);
    assign tmr_val  = (state == ST_SHIFT) ? TW'(LOAD_CYC - 1) : TW'(GAP_CYC - 1);

    dws_sclk_gen #(.DIV(DIV), .NBITS(FRAME_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT),
        .sclk(sclk), .fall_pt(fall_pt), .last_bit(last_bit)
    );

    dws_shifter #(.FW(FRAME_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .load(state == ST_CHECK),
        .shift(fall_pt && !last_bit), .frame_in(frame), .msb(msb)
    );

    dws_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );
endmodule

// File: rtl/dac_write_seq_chk.sv
module dac_write_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic en,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic load_n,
    input logic busy
);
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && en) |=> busy);
    a_r2_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en) |=> !busy);
    a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r4_sdo_stable: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdo));
    a_r5_cs_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (!cs_n && $past(!cs_n)));
    a_r6_load_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> cs_n);
    a_r7_rest_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cs_n && load_n));
endmodule

bind dac_write_seq dac_write_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .en(en),
    .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .load_n(load_n), .busy(busy)
);

// File: tb/dac_write_seq_test.sv
module dac_write_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic [11:0] sample = '0;
    logic en = 1'b0;
    logic gain_hi = 1'b0;
    logic pwr_down = 1'b0;
    logic cs_n, sclk, sdo, load_n, busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dac_write_seq uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .sample(sample),
        .en(en), .gain_hi(gain_hi), .pwr_down(pwr_down),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .load_n(load_n), .busy(busy)
    );

    // {sample[11:0], gain_hi, pwr_down, expected frame[15:0]}
    localparam logic [29:0] VEC [5] = '{
        {12'hA5C, 1'b0, 1'b0, 16'h3A5C},
        {12'hFFF, 1'b1, 1'b0, 16'h1FFF},
        {12'h000, 1'b0, 1'b1, 16'h2000},
        {12'h801, 1'b1, 1'b1, 16'h0801},
        {12'h3C7, 1'b0, 1'b0, 16'h33C7}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rest_check(input string req);
        check(cs_n == 1'b1,   req, int'(cs_n), 1);
        check(sclk == 1'b0,   req, int'(sclk), 0);
        check(sdo == 1'b0,    req, int'(sdo), 0);
        check(load_n == 1'b1, req, int'(load_n), 1);
        check(busy == 1'b0,   req, int'(busy), 0);
    endtask

    task automatic run_frame(input logic [11:0] d, input logic g, input logic p,
                             input logic [15:0] exp, input bit poke);
        logic [15:0] fr = '0;
        int nb = 0, ldc = 0, gap = 0, lead = 0, cs_fall_k = 0, last_rise = 0;
        int v_per = 0, v_idle = 0, v_stab = 0, v_ld = 0, v_cs = 0;
        logic prev_sclk = 1'b0, prev_sdo = 1'b0, prev_cs = 1'b1;
        @(negedge clk);
        sample = d; gain_hi = g; pwr_down = p; en = 1'b1; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
        sample = ~d; gain_hi = ~g; pwr_down = ~p;
        for (int k = 0; k < 400; k++) begin
            if (!busy) break;
            if (poke && k == 20) begin start_req = 1'b1; sample = 12'h555; end
            if (!cs_n && prev_cs) cs_fall_k = k;
            if (sclk && !prev_sclk) begin
                if (cs_n) v_cs++;
                fr = {fr[14:0], sdo};
                nb++;
                if (nb == 1) lead = k - cs_fall_k;
                else if (k - last_rise != 4) v_per++;
                last_rise = k;
            end
            if (cs_n && sclk) v_idle++;
            if (sclk && prev_sclk && sdo != prev_sdo) v_stab++;
            if (!load_n) begin
                ldc++;
                if (!cs_n || nb != 16) v_ld++;
            end
            if (load_n && ldc > 0) gap++;
            prev_sclk = sclk; prev_sdo = sdo; prev_cs = cs_n;
            @(negedge clk);
        end
        start_req = 1'b0;
        check(fr == exp, "R3 frame bits", int'(fr), int'(exp));
        check(fr == exp, "R8 held inputs", int'(fr), int'(exp));
        check(nb == 16, "R4 rising edge count", nb, 16);
        check(v_per == 0 && v_idle == 0 && v_stab == 0, "R4 sclk timing", v_per + v_idle + v_stab, 0);
        check(lead >= 2 && v_cs == 0, "R5 chip select lead", lead, 3);
        check(ldc == 4, "R6 strobe length", ldc, 4);
        check(v_ld == 0, "R6 strobe order", v_ld, 0);
        check(gap == 9, "R7 idle gap", gap, 9);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rest_check("R9 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        rest_check("R9 after reset");

        for (int i = 0; i < 5; i++)
            run_frame(VEC[i][29:18], VEC[i][17], VEC[i][16], VEC[i][15:0], 1'b0);

        // R2: requests while disabled
        @(negedge clk);
        en = 1'b0; start_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(busy == 1'b0 && cs_n == 1'b1, "R2 disabled request", int'(busy), 0);
        end
        start_req = 1'b0; en = 1'b1;

        // R2: request held during a frame is dropped; frame stays intact (R8)
        run_frame(12'h6B2, 1'b1, 1'b0, 16'h16B2, 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(busy == 1'b0 && cs_n == 1'b1, "R2 busy request dropped", int'(busy), 0);
        end

        // R9: reset in mid-frame
        @(negedge clk);
        sample = 12'h123; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rest_check("R9 mid-frame reset");
        rst_n = 1'b1;
        run_frame(12'h0F0, 1'b0, 1'b1, 16'h20F0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule